// File: doc/BRIEF.md
# User I/O Register Bank

This block is a word-addressed bank of 32-bit registers. Through it, software drives four status LEDs, four red LEDs, four green LEDs and two seven-segment digits, each digit with a decimal point. It also reads three push buttons and a four-position DIP switch. The bus is a plain synchronous port: a word address, a write strobe, write data and registered read data.

Software packs the 28 output bits into one source vector. Each bit goes through two selects. The control register picks software or hardware for the bit. The hardware-select register then picks, for a bit under hardware control, either the matching bit of an external port or a shared PWM level that comes from outside the block.

Each digit has a mode bit:
- In raw mode, the written bits drive the segments directly.
- In hex mode, a nibble is decoded internally into segments.

The decimal point does not depend on the mode. The button and switch inputs pass through a synchronizer before they appear in the read-only input register.

Top module: `uio_regbank`

## Requirements
- R1: After reset, every register reads zero and every LED, segment and decimal-point output is 0.
- R2: The word offsets are control 0, left digit 1, right digit 2, status LEDs 3, red LEDs 4, green LEDs 5, inputs 6 and hardware select 10. The stored fields are control [29:0], digit [8] and [6:0], LED [3:0] and hardware select [27:0]. Other bits read zero. Read data is the register at the address presented one clock earlier.
- R3: The 28-bit source vector is laid out as [27:24] status LEDs, [23:20] red, [19:16] green, [15] right point, [14:8] right segments g..a, [7] left point and [6:0] left segments g..a, with segment a at the lowest bit of each group. When a control bit is 0, that output follows the software register, and 1 means lit.
- R4: When a control bit is 1 and the matching hardware-select bit is 0, that output follows the same bit of hw_out_i.
- R5: When a control bit is 1 and the matching hardware-select bit is 1, that output follows pwm_i.
- R6: Control bit 29 puts the left digit in hex mode and bit 28 the right digit. In hex mode, data bits [3:0] are decoded to g..a as 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71, and data bits [6:4] are ignored.
- R7: In raw mode, data bits [6:0] drive segments g..a directly. Digit register bit 8 drives the decimal point in both modes.
- R8: Reading an output register returns the stored software value, whatever source currently drives the pins.
- R9: The input register at offset 6 reads {up, mid, down} at bits [6:4] and the DIP switch at [3:0], with bit 0 as the right-most position. Inputs are seen only after a two-flop synchronizer. Writes to offset 6 change nothing.
- R10: Offsets 7, 8, 9 and 11 to 15 read zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| hw_out_i | input | 28 | Hardware port values in source-vector layout |
| pwm_i | input | 1 | Shared PWM level |
| btn_up_i | input | 1 | Up button |
| btn_mid_i | input | 1 | Middle button |
| btn_down_i | input | 1 | Down button |
| dip_i | input | 4 | DIP switch |
| status_led_o | output | 4 | {B red, B green, A red, A green} |
| red_led_o | output | 4 | Red LEDs |
| green_led_o | output | 4 | Green LEDs |
| seg_left_o | output | 7 | Left segments g..a |
| dp_left_o | output | 1 | Left decimal point |
| seg_right_o | output | 7 | Right segments g..a |
| dp_right_o | output | 1 | Right decimal point |

## Verification
The bench builds the block with its default values: ADDR_W = 4 and SYNC_STAGES = 2. With a four-bit address, every unmapped offset from 7 to 15 can be reached, including those above the hardware-select register. The two-stage synchronizer makes the input latency short enough to test that a changed switch value is not visible one clock later. The full decode table is walked with junk in data bits [6:4]. The three source paths are compared on a single LED group while the stored software value is read back.

// File: rtl/uio_pkg.sv
package uio_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned LED_W   = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned OUT_W   = 3 * LED_W + 2 * (SEG_W + 1);
  localparam int unsigned IN_W    = 3 + LED_W;
  localparam int unsigned CTRL_W  = OUT_W + 2;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_LEFT  = 1;
  localparam int unsigned OFF_RIGHT = 2;
  localparam int unsigned OFF_STAT  = 3;
  localparam int unsigned OFF_RED   = 4;
  localparam int unsigned OFF_GRN   = 5;
  localparam int unsigned OFF_IN    = 6;
  localparam int unsigned OFF_HWSEL = 10;
  localparam int unsigned BIT_HEX_L = OUT_W + 1;
  localparam int unsigned BIT_HEX_R = OUT_W;
endpackage

// File: rtl/uio_sync.sv
module uio_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
    a_r9_sync_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/uio_hex_dec.sv
module uio_hex_dec (
  input  logic [3:0] nib_i,
  output logic [6:0] seg_o
);
  // active-high, bit 0 = segment a
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/uio_src_mux.sv
module uio_src_mux #(
  parameter int unsigned WIDTH = 28
) (
  input  logic [WIDTH-1:0] sw_i,
  input  logic [WIDTH-1:0] hw_i,
  input  logic             pwm_i,
  input  logic [WIDTH-1:0] hw_en_i,
  input  logic [WIDTH-1:0] pwm_en_i,
  output logic [WIDTH-1:0] out_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic hw_bit;
    assign hw_bit   = pwm_en_i[b] ? pwm_i : hw_i[b];
    assign out_o[b] = hw_en_i[b] ? hw_bit : sw_i[b];
  end
endmodule

// File: rtl/uio_regbank.sv
module uio_regbank
  import uio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [OUT_W-1:0]  hw_out_i,
  input  logic              pwm_i,
  input  logic              btn_up_i,
  input  logic              btn_mid_i,
  input  logic              btn_down_i,
  input  logic [LED_W-1:0]  dip_i,
  output logic [LED_W-1:0]  status_led_o,
  output logic [LED_W-1:0]  red_led_o,
  output logic [LED_W-1:0]  green_led_o,
  output logic [SEG_W-1:0]  seg_left_o,
  output logic              dp_left_o,
  output logic [SEG_W-1:0]  seg_right_o,
  output logic              dp_right_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [OUT_W-1:0]  hwsel_q;
  logic [SEG_W-1:0]  left_q, right_q;
  logic              left_dp_q, right_dp_q;
  logic [LED_W-1:0]  stat_q, red_q, grn_q;
  logic [IN_W-1:0]   in_sync;
  logic [REG_W-1:0]  rd_next;
  logic              mapped;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[REG_W-1:CTRL_W], wr_data_i[SEG_W]};

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      hwsel_q    <= '0;
      left_q     <= '0;
      right_q    <= '0;
      left_dp_q  <= 1'b0;
      right_dp_q <= 1'b0;
      stat_q     <= '0;
      red_q      <= '0;
      grn_q      <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, OFF_CTRL))  ctrl_q  <= wr_data_i[CTRL_W-1:0];
      if (hit(addr_i, OFF_HWSEL)) hwsel_q <= wr_data_i[OUT_W-1:0];
      if (hit(addr_i, OFF_LEFT)) begin
        left_q    <= wr_data_i[SEG_W-1:0];
        left_dp_q <= wr_data_i[SEG_W+1];
      end
      if (hit(addr_i, OFF_RIGHT)) begin
        right_q    <= wr_data_i[SEG_W-1:0];
        right_dp_q <= wr_data_i[SEG_W+1];
      end
      if (hit(addr_i, OFF_STAT)) stat_q <= wr_data_i[LED_W-1:0];
      if (hit(addr_i, OFF_RED))  red_q  <= wr_data_i[LED_W-1:0];
      if (hit(addr_i, OFF_GRN))  grn_q  <= wr_data_i[LED_W-1:0];
    end
  end

  uio_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({btn_up_i, btn_mid_i, btn_down_i, dip_i}),
    .q_o    (in_sync)
  );

  // digit segment sources
  logic [SEG_W-1:0] left_dec, right_dec, left_sw, right_sw;

  uio_hex_dec u_dec_l (.nib_i(left_q[3:0]),  .seg_o(left_dec));
  uio_hex_dec u_dec_r (.nib_i(right_q[3:0]), .seg_o(right_dec));

  assign left_sw  = ctrl_q[BIT_HEX_L] ? left_dec  : left_q;
  assign right_sw = ctrl_q[BIT_HEX_R] ? right_dec : right_q;

  logic [OUT_W-1:0] sw_vec, out_vec;
  assign sw_vec = {stat_q, red_q, grn_q, right_dp_q, right_sw, left_dp_q, left_sw};

  uio_src_mux #(.WIDTH(OUT_W)) u_mux (
    .sw_i     (sw_vec),
    .hw_i     (hw_out_i),
    .pwm_i    (pwm_i),
    .hw_en_i  (ctrl_q[OUT_W-1:0]),
    .pwm_en_i (hwsel_q),
    .out_o    (out_vec)
  );

  assign status_led_o = out_vec[27:24];
  assign red_led_o    = out_vec[23:20];
  assign green_led_o  = out_vec[19:16];
  assign dp_right_o   = out_vec[15];
  assign seg_right_o  = out_vec[14:8];
  assign dp_left_o    = out_vec[7];
  assign seg_left_o   = out_vec[6:0];

  // readback
  always_comb begin
    rd_next = '0;
    if (hit(addr_i, OFF_CTRL))  rd_next = REG_W'(ctrl_q);
    if (hit(addr_i, OFF_HWSEL)) rd_next = REG_W'(hwsel_q);
    if (hit(addr_i, OFF_LEFT))  rd_next = REG_W'({left_dp_q, 1'b0, left_q});
    if (hit(addr_i, OFF_RIGHT)) rd_next = REG_W'({right_dp_q, 1'b0, right_q});
    if (hit(addr_i, OFF_STAT))  rd_next = REG_W'(stat_q);
    if (hit(addr_i, OFF_RED))   rd_next = REG_W'(red_q);
    if (hit(addr_i, OFF_GRN))   rd_next = REG_W'(grn_q);
    if (hit(addr_i, OFF_IN))    rd_next = REG_W'(in_sync);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end

  assign mapped = (addr_i <= ADDR_W'(OFF_IN)) || hit(addr_i, OFF_HWSEL);

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |=> rd_data_o == '0);

  a_r9_input_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && hit(addr_i, OFF_IN) |=> $stable(ctrl_q) && $stable(hwsel_q) && $stable(sw_vec));

  a_r3_sw_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && hit(addr_i, OFF_STAT) && ctrl_q[27:24] == '0
      |=> status_led_o == $past(wr_data_i[LED_W-1:0]));

  a_r5_pwm_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[27:24] == 4'hF && hwsel_q[27:24] == 4'hF |-> status_led_o == {LED_W{pwm_i}});
endmodule

// File: tb/uio_regbank_tb_top.sv
module uio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [27:0] hw = '0;
  logic        pwm = 1'b0;
  logic        b_up = 1'b0, b_mid = 1'b0, b_dn = 1'b0;
  logic [3:0]  dip = '0;
  logic [3:0]  st_o, rd_o, gr_o;
  logic [6:0]  sl_o, sr_o;
  logic        dl_o, dr_o;
  int n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #2ns clk = ~clk;

  uio_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .hw_out_i(hw), .pwm_i(pwm), .btn_up_i(b_up), .btn_mid_i(b_mid),
    .btn_down_i(b_dn), .dip_i(dip), .status_led_o(st_o), .red_led_o(rd_o),
    .green_led_o(gr_o), .seg_left_o(sl_o), .dp_left_o(dl_o), .seg_right_o(sr_o),
    .dp_right_o(dr_o)
  );

  // {stimulus data[6:0], expected segments g..a}
  localparam logic [13:0] HEX_VEC [16] = '{
    {7'h00, 7'h3F}, {7'h11, 7'h06}, {7'h22, 7'h5B}, {7'h33, 7'h4F},
    {7'h44, 7'h66}, {7'h55, 7'h6D}, {7'h66, 7'h7D}, {7'h77, 7'h07},
    {7'h08, 7'h7F}, {7'h19, 7'h6F}, {7'h2A, 7'h77}, {7'h3B, 7'h7C},
    {7'h4C, 7'h39}, {7'h5D, 7'h5E}, {7'h6E, 7'h79}, {7'h7F, 7'h71}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdr(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); v = rd;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rdr(4'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 outs", {st_o, rd_o, gr_o, dr_o, sr_o, dl_o, sl_o}, 0);

    // R2 field widths and readback
    wr(0, 32'hCFFF_FFFF); rdr(0, v); chk("R2 ctrl", v, 32'h0FFF_FFFF);
    wr(0, 32'h0);
    wr(1, 32'hFFFF_FFFF); rdr(1, v); chk("R2 left", v, 32'h17F);
    wr(3, 32'hFFFF_FFF6); rdr(3, v); chk("R2 stat", v, 32'h6);
    wr(10, 32'hFFFF_FFFF); rdr(10, v); chk("R2 hwsel", v, 32'h0FFF_FFFF);
    wr(10, 32'h0);

    // R3 software drive
    wr(3, 9); wr(4, 5); wr(5, 4'hA);
    chk("R3 stat", st_o, 9); chk("R3 red", rd_o, 5); chk("R3 green", gr_o, 4'hA);

    // R7 raw mode and point
    wr(1, 32'h155); chk("R7 left raw", {dl_o, sl_o}, {1'b1, 7'h55});
    wr(2, 32'h02A); chk("R7 right raw", {dr_o, sr_o}, {1'b0, 7'h2A});

    // R4 hardware port on red group, R8 readback unchanged
    hw = 28'h0A0_0000;
    wr(0, 32'h00F0_0000);
    chk("R4 red hw", rd_o, 4'hA); chk("R4 green sw", gr_o, 4'hA);
    rdr(4, v); chk("R8 red stored", v, 5);

    // R5 pwm on red group
    wr(10, 32'h00F0_0000);
    pwm = 1'b1; #1ns; chk("R5 pwm hi", rd_o, 4'hF);
    pwm = 1'b0; #1ns; chk("R5 pwm lo", rd_o, 4'h0);
    chk("R5 stat sw", st_o, 9);

    // R6 hex decode table, left digit
    wr(0, 32'h2000_0000);
    for (int i = 0; i < 16; i++) begin
      wr(1, {25'b0, HEX_VEC[i][13:7]});
      chk("R6 hex left", {dl_o, sl_o}, {1'b0, HEX_VEC[i][6:0]});
    end
    wr(1, 32'h10B); chk("R7 dp in hex", {dl_o, sl_o}, {1'b1, 7'h7C});
    chk("R6 right raw kept", sr_o, 7'h2A);
    wr(0, 32'h1000_0000); wr(2, 32'h00D);
    chk("R6 hex right", sr_o, 7'h5E); chk("R6 left raw again", sl_o, 7'h0B);

    // R9 input register
    b_up = 1; b_mid = 0; b_dn = 1; dip = 4'h6;
    repeat (3) @(negedge clk);
    rdr(6, v); chk("R9 inputs", v, 32'h56);
    dip = 4'h9;
    rdr(6, v); chk("R9 sync delay", v, 32'h56);
    repeat (2) @(negedge clk);
    rdr(6, v); chk("R9 inputs new", v, 32'h59);
    wr(6, 32'hFFFF_FFFF);
    rdr(6, v); chk("R9 ro", v, 32'h59);
    rdr(0, v); chk("R9 ctrl kept", v, 32'h1000_0000);

    // R10 unmapped offsets
    for (int a = 7; a < 16; a++) begin
      if (a != 10) begin
        wr(4'(a), 32'hFFFF_FFFF);
        rdr(4'(a), v); chk("R10 unmapped read", v, 0);
      end
    end
    rdr(0, v);  chk("R10 ctrl kept", v, 32'h1000_0000);
    rdr(10, v); chk("R10 hwsel kept", v, 32'h00F0_0000);
    chk("R10 outs kept", {st_o, gr_o, dr_o, sr_o, dl_o, sl_o},
        {4'h9, 4'hA, 1'b0, 7'h5E, 1'b1, 7'h0B});

    summary();
  end
endmodule